// File: doc/BRIEF.md
# Two-Channel Chained Address Breakpoint

This unit watches the virtual addresses that a processor core reports, together with a valid qualifier. It compares each valid address against two software-programmed break addresses, channel A and channel B. When the programmed condition is met it sends the core a single-cycle break request. Software programs the unit through a small register bus. That bus holds the two address registers and one control/status word. The control/status word carries a mode bit that chains the channels and a sticky hit flag for each channel.

In independent mode, a hit on either channel raises the break. In chained mode, channel A must hit first. The unit remembers that hit, and a later hit on channel B raises the break and sets both flags. Once a break has been taken, the unit stays quiet until software writes zeros to the flags. This lets a debugger take exactly one break per arming.

Top module: `brk_pair_unit`

## Requirements
- R1: The channel A address register (offset 0x0) and the channel B address register (offset 0x4) are each 32 bits wide, read/write, and are not reset. Read data appears on `cfg_rdata` in the cycle after the read strobe, and `cfg_rdata` holds it until the next read.
- R2: The control/status word sits at offset 0x8. Bit 0 is the chain-mode bit, bit 1 is the channel A hit flag, and bit 2 is the channel B hit flag. Bits 31..3 always read 0. The flags cannot be set by a write.
- R3: In independent mode with both flags clear, a valid address equal to only one channel's register produces `brk_req` high for exactly one cycle, in the cycle after the address. Only that channel's flag is set.
- R4: In independent mode, a valid address that equals both registers produces one pulse and sets both flags.
- R5: An address presented while `mon_valid` is low has no effect on `brk_req` or on the flags.
- R6: In chained mode, a channel B hit with no prior channel A hit produces no pulse and leaves both flags at 0.
- R7: In chained mode, a channel A hit followed in a later cycle by a channel B hit produces one pulse and sets both flags.
- R8: In chained mode, a single address that hits both channels when no channel A hit is held produces no pulse. It does leave the channel A hit held, so that the next channel B hit breaks.
- R9: While either flag is 1, no hit produces a pulse.
- R10: Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. With both flags cleared, the unit breaks again.
- R11: In chained mode, a control write with bit 1 equal to 0 discards a held channel A hit.
- R12: After a synchronous reset, `brk_req` is 0, `cfg_rdata` is 0 and the control/status word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data |
| mon_valid | input | 1 | Monitored address is valid this cycle |
| mon_addr | input | 32 | Monitored virtual address |
| brk_req | output | 1 | Single-cycle break request to the core |

## Verification
The assertions assume the following about the inputs:
- Software never writes the control word in the same cycle as a valid monitored address.
- A write and a read are never both strobed.
- Address registers are programmed before any hit is expected, since they come out of reset undefined.

The stimulus follows these rules. Every register access is made with `mon_valid` low, and the break addresses are written at the start of the run. Monitored addresses are presented one cycle at a time, each followed by an idle cycle.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int REG_AW = 4;
  localparam int NCH = 2;
  localparam int CH_A = 0;
  localparam int CH_B = 1;
  localparam logic [REG_AW-1:0] OFS_BAR_A = 4'h0;
  localparam logic [REG_AW-1:0] OFS_BAR_B = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CTL = 4'h8;
  localparam int BIT_SEQ = 0;
  localparam int BIT_FA = 1;
  localparam int BIT_FB = 2;

  typedef struct packed {
    logic wr;
    logic keep_a;
    logic keep_b;
  } ctl_wr_t;
endpackage

// File: rtl/brk_regfile.sv
module brk_regfile
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_wr,
  input  logic                          cfg_rd,
  input  logic [REG_AW-1:0]             cfg_addr,
  input  logic [ADDR_W-1:0]             cfg_wdata,
  output logic [ADDR_W-1:0]             cfg_rdata,
  input  logic                          flag_a,
  input  logic                          flag_b,
  output logic                          seq_mode,
  output ctl_wr_t                       ctl_wr,
  output logic [NCH-1:0][ADDR_W-1:0]    bar
);
  logic [ADDR_W-1:0] rd_mux;

  // Break addresses carry no reset, matching plain FPGA fabric registers.
  always_ff @(posedge clk) begin
    if (cfg_wr && cfg_addr == OFS_BAR_A) bar[CH_A] <= cfg_wdata;
    if (cfg_wr && cfg_addr == OFS_BAR_B) bar[CH_B] <= cfg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)
      seq_mode <= 1'b0;
    else if (cfg_wr && cfg_addr == OFS_CTL)
      seq_mode <= cfg_wdata[BIT_SEQ];
  end

  always_comb begin
    ctl_wr.wr     = cfg_wr && (cfg_addr == OFS_CTL);
    ctl_wr.keep_a = cfg_wdata[BIT_FA];
    ctl_wr.keep_b = cfg_wdata[BIT_FB];
  end

  always_comb begin
    rd_mux = '0;
    unique case (cfg_addr)
      OFS_BAR_A: rd_mux = bar[CH_A];
      OFS_BAR_B: rd_mux = bar[CH_B];
      OFS_CTL: begin
        rd_mux[BIT_SEQ] = seq_mode;
        rd_mux[BIT_FA]  = flag_a;
        rd_mux[BIT_FB]  = flag_b;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= '0;
    else if (cfg_rd)
      cfg_rdata <= rd_mux;
  end
endmodule

// File: rtl/brk_match.sv
module brk_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                       mon_valid,
  input  logic [ADDR_W-1:0]          mon_addr,
  input  logic [NCH-1:0][ADDR_W-1:0] bar,
  output logic [NCH-1:0]             hit
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    assign hit[ch] = mon_valid && (mon_addr == bar[ch]);
  end
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           seq_mode,
  input  logic [NCH-1:0] hit,
  input  ctl_wr_t        ctl_wr,
  output logic           flag_a,
  output logic           flag_b,
  output logic           seq_pend,
  output logic           brk_req
);
  logic fa_n, fb_n, pend_n, fire, armed;

  always_comb begin
    fa_n   = flag_a;
    fb_n   = flag_b;
    pend_n = seq_pend;
    fire   = 1'b0;
    armed  = !flag_a && !flag_b;
    if (ctl_wr.wr) begin
      fa_n = flag_a & ctl_wr.keep_a;
      fb_n = flag_b & ctl_wr.keep_b;
      if (!ctl_wr.keep_a) pend_n = 1'b0;
    end
    if (armed) begin
      if (!seq_mode) begin
        fire = |hit;
        fa_n = fa_n | hit[CH_A];
        fb_n = fb_n | hit[CH_B];
      end else if (seq_pend && hit[CH_B]) begin
        fire   = 1'b1;
        fa_n   = 1'b1;
        fb_n   = 1'b1;
        pend_n = 1'b0;
      end else if (hit[CH_A]) begin
        pend_n = 1'b1;
      end
    end
    if (!seq_mode) pend_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      seq_pend <= 1'b0;
      brk_req  <= 1'b0;
    end else begin
      flag_a   <= fa_n;
      flag_b   <= fb_n;
      seq_pend <= pend_n;
      brk_req  <= fire;
    end
  end
endmodule

// File: rtl/brk_pair_unit.sv
module brk_pair_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              mon_valid,
  input  logic [ADDR_W-1:0] mon_addr,
  output logic              brk_req
);
  logic [NCH-1:0][ADDR_W-1:0] bar;
  logic [NCH-1:0]             hit;
  logic                       seq_mode, flag_a, flag_b, seq_pend;
  ctl_wr_t                    ctl_wr;

  brk_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .flag_a(flag_a), .flag_b(flag_b), .seq_mode(seq_mode),
    .ctl_wr(ctl_wr), .bar(bar)
  );

  brk_match #(.ADDR_W(ADDR_W)) u_match (
    .mon_valid(mon_valid), .mon_addr(mon_addr), .bar(bar), .hit(hit)
  );

  brk_seq u_seq (
    .clk(clk), .rst(rst), .seq_mode(seq_mode), .hit(hit), .ctl_wr(ctl_wr),
    .flag_a(flag_a), .flag_b(flag_b), .seq_pend(seq_pend), .brk_req(brk_req)
  );
endmodule

// File: rtl/brk_pair_chk.sv
module brk_pair_chk
  import brk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic [REG_AW-1:0] cfg_addr,
  input logic              mon_valid,
  input logic              brk_req,
  input logic              flag_a,
  input logic              flag_b,
  input logic              seq_mode,
  input logic              seq_pend
);
  logic ctl_w;
  assign ctl_w = cfg_wr && (cfg_addr == OFS_CTL);

  // R3: a break request lasts a single cycle
  p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
    brk_req |=> !brk_req);

  // R5: no valid address, no break in the following cycle
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    !mon_valid |=> !brk_req);

  // R9: a break always leaves at least one flag set
  p_flag_on_break_r9: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (flag_a || flag_b));

  // R7: a chained break sets both flags
  p_chain_flags_r7: assert property (@(posedge clk) disable iff (rst)
    (brk_req && $past(seq_mode)) |-> (flag_a && flag_b));

  // R6: a chained break needs a held channel A hit
  p_chain_needs_a_r6: assert property (@(posedge clk) disable iff (rst)
    (brk_req && $past(seq_mode)) |-> $past(seq_pend));

  // R10: flags stay set without a control write
  p_sticky_a_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_a && !ctl_w) |=> flag_a);
  p_sticky_b_r10: assert property (@(posedge clk) disable iff (rst)
    (flag_b && !ctl_w) |=> flag_b);

  // R11: held channel A state only exists in chained mode
  p_pend_mode_r11: assert property (@(posedge clk) disable iff (rst)
    !seq_mode |=> !seq_pend);
endmodule

bind brk_pair_unit brk_pair_chk u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
  .mon_valid(mon_valid), .brk_req(brk_req), .flag_a(flag_a),
  .flag_b(flag_b), .seq_mode(seq_mode), .seq_pend(seq_pend)
);

// File: tb/brk_pair_unit_tb.sv
module brk_pair_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        mon_valid = 1'b0;
  logic [31:0] mon_addr = '0;
  logic        brk_req;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  localparam logic [31:0] AV = 32'h1234_5678;
  localparam logic [31:0] BV = 32'hCAFE_0004;
  localparam logic [31:0] OTHER = 32'h0000_0100;

  always #10 clk = ~clk;

  brk_pair_unit u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mon_valid(mon_valid), .mon_addr(mon_addr), .brk_req(brk_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); cfg_rd = 1'b1; cfg_addr = a;
    @(negedge clk); cfg_rd = 1'b0; d = cfg_rdata;
  endtask

  // present one valid address, return the break request of the next cycle
  task automatic show(input logic [31:0] a, input logic v, output logic p);
    @(negedge clk); mon_valid = v; mon_addr = a;
    @(negedge clk); mon_valid = 1'b0; p = brk_req;
    @(negedge clk);
    if (brk_req !== 1'b0) chk("R3 pulse width", {31'b0, brk_req}, 32'h0);
  endtask

  task automatic ctl_is(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(4'h8, d);
    chk(req, d, exp);
  endtask

  task automatic t_reset();
    chk("R12 rdata", cfg_rdata, 32'h0);
    chk("R12 brk_req", {31'b0, brk_req}, 32'h0);
    ctl_is("R12 ctl", 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(4'h0, AV); wr(4'h4, BV);
    rd(4'h0, d); chk("R1 bar A", d, AV);
    rd(4'h4, d); chk("R1 bar B", d, BV);
    @(negedge clk); chk("R1 rdata held", cfg_rdata, BV);
    wr(4'h8, 32'h1); ctl_is("R2 seq bit", 32'h1);
    wr(4'h8, 32'hFFFF_FFF8); ctl_is("R2 unused and flags", 32'h0);
  endtask

  task automatic t_single();
    logic p;
    show(AV, 1'b1, p); chk("R3 pulse A", {31'b0, p}, 32'h1);
    ctl_is("R3 flag A only", 32'h2);
    show(AV, 1'b1, p); chk("R9 no repeat", {31'b0, p}, 32'h0);
    show(BV, 1'b1, p); chk("R9 no B while set", {31'b0, p}, 32'h0);
    ctl_is("R9 flags unchanged", 32'h2);
    wr(4'h8, 32'h0); ctl_is("R10 clear A", 32'h0);
    show(BV, 1'b1, p); chk("R3 pulse B", {31'b0, p}, 32'h1);
    ctl_is("R3 flag B only", 32'h4);
    wr(4'h8, 32'h2); ctl_is("R10 keep-1 clear B", 32'h0);
  endtask

  task automatic t_both();
    logic p;
    wr(4'h4, AV);
    show(AV, 1'b1, p); chk("R4 pulse", {31'b0, p}, 32'h1);
    ctl_is("R4 both flags", 32'h6);
    wr(4'h8, 32'h4); ctl_is("R10 partial clear", 32'h4);
    wr(4'h8, 32'h0); wr(4'h4, BV);
  endtask

  task automatic t_novalid();
    logic p;
    show(AV, 1'b0, p); chk("R5 no pulse", {31'b0, p}, 32'h0);
    ctl_is("R5 no flags", 32'h0);
  endtask

  task automatic t_chain();
    logic p;
    wr(4'h8, 32'h1);
    show(BV, 1'b1, p); chk("R6 B first", {31'b0, p}, 32'h0);
    ctl_is("R6 flags zero", 32'h1);
    show(AV, 1'b1, p); chk("R7 A alone", {31'b0, p}, 32'h0);
    show(OTHER, 1'b1, p); chk("R7 other", {31'b0, p}, 32'h0);
    show(BV, 1'b1, p); chk("R7 chained pulse", {31'b0, p}, 32'h1);
    ctl_is("R7 both flags", 32'h7);
    show(AV, 1'b1, p); show(BV, 1'b1, p); chk("R9 chained hold", {31'b0, p}, 32'h0);
    wr(4'h8, 32'h1); ctl_is("R10 cleared", 32'h1);
  endtask

  task automatic t_same();
    logic p;
    wr(4'h4, AV);
    show(AV, 1'b1, p); chk("R8 same cycle", {31'b0, p}, 32'h0);
    show(AV, 1'b1, p); chk("R8 held A then B", {31'b0, p}, 32'h1);
    wr(4'h4, BV); wr(4'h8, 32'h1);
  endtask

  task automatic t_discard();
    logic p;
    show(AV, 1'b1, p);
    wr(4'h8, 32'h1);
    show(BV, 1'b1, p); chk("R11 discarded", {31'b0, p}, 32'h0);
    show(AV, 1'b1, p); show(BV, 1'b1, p); chk("R10 rearm", {31'b0, p}, 32'h1);
    wr(4'h8, 32'h0); ctl_is("R10 final", 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset(); t_regs(); t_single(); t_both(); t_novalid();
    t_chain(); t_same(); t_discard();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule